// File: doc/BRIEF.md
# Lane Receive Descrambler with Control-Character Substitution

This block sits in a serial-link lane receiver after the 8b/10b decoder. Each clock it may accept a 16-bit word made of two octets. Each octet arrives with a flag that marks it as a control character. The block removes the transmitter's scrambling with a self-synchronous descrambler whose polynomial is 1 + x^14 + x^15. All 16 bits are handled in parallel in one clock. A configuration input switches the descrambler off, and the received data then passes through as it arrived.

Flagged lane-alignment and frame-alignment characters are substituted in both modes. With scrambling off, either character is replaced by the octet the block last put out. This keeps the sample stream continuous. With scrambling on, the data octet that has the same 8-bit value as the character is put out. The result is registered, so each accepted word appears at the outputs one clock later with a valid strobe.

Top module: `lane_descramble_replace`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_data` to zero. It also clears the descrambler history and the last-output-octet register to zero, so the first scrambled word after reset is descrambled against all-zero history.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `out_data` takes the result of an accepted word at that same edge.
- R3: While `in_valid` is low, `out_data` holds its value. The descrambler history and the last-output-octet register do not change, so the next accepted word gives the same result as if the idle cycles had not occurred.
- R4: With `scr_en` high, each output bit is the received bit XOR the received bits 14 and 15 positions earlier in the serial stream. The serial order is `in_data[15]` first and down to `in_data[0]`. The first octet is `in_data[15:8]`, flagged by `in_ctrl[1]`. The second octet is `in_data[7:0]`, flagged by `in_ctrl[0]`.
- R5: The descrambler history is built only from received bits. After any one accepted word, the output for the following words does not depend on the state before that word.
- R6: With `scr_en` low, an octet goes to the output unchanged when its control flag is clear. It also goes through unchanged when its flag is set but its value is neither 0x7C nor 0xFC.
- R7: With `scr_en` low, a flagged octet of value 0x7C (lane alignment) or 0xFC (frame alignment) is replaced by the previous output octet. For the first octet, that is the second octet of the last output word. For the second octet, it is the first octet of the same output word, after any replacement of that first octet.
- R8: With `scr_en` high, a flagged octet of value 0x7C is output as 0x7C and one of value 0xFC as 0xFC, whatever the descrambled value. Any other flagged octet is output descrambled.
- R9: The descrambler history advances on every accepted word in both modes, so a switch of `scr_en` between words takes effect at once with correct history.
- R10: The last-output-octet register follows the output in both modes, so a replacement right after a switch to `scr_en` low uses the octet last output while scrambling was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scr_en | input | 1 | 1 = descramble received words, 0 = pass through |
| in_valid | input | 1 | Input word is present this cycle |
| in_ctrl | input | 2 | Control-character flags; bit 1 for the first octet, bit 0 for the second |
| in_data | input | 16 | Received word; [15:8] first octet, [7:0] second octet |
| out_valid | output | 1 | Output word was updated at the last edge |
| out_data | output | 16 | Descrambled and substituted word |

## Verification
Every result is due exactly one rising edge after its word is presented. This covers the descrambled bits, the substitutions and the valid strobe. An idle cycle is likewise due one edge later, as a low strobe with the data unchanged. The bench drives each word on a falling edge and samples on the next falling edge, after exactly one rising edge. It then drives the next word in that same half-cycle, so back-to-back words are checked with no gaps. The reference model advances its history and previous-octet state only for accepted words. Because of this, checks on idle gaps, mode switches and mid-run resets all compare against the state the requirements define.

// File: rtl/lanerx_pkg.sv
`timescale 1ns/1ps
package lanerx_pkg;

    localparam int unsigned OCT_W = 8;

    // Octet values that identify alignment control characters
    localparam logic [OCT_W-1:0] SYM_LANE_MARK  = 8'h7C;
    localparam logic [OCT_W-1:0] SYM_FRAME_MARK = 8'hFC;

    typedef enum logic [1:0] {
        OCT_DATA,
        OCT_LANE_MARK,
        OCT_FRAME_MARK,
        OCT_OTHER_CTRL
    } octet_kind_e;

    function automatic octet_kind_e classify_octet(
        input logic [OCT_W-1:0] value,
        input logic             is_ctrl
    );
        if (!is_ctrl)                     return OCT_DATA;
        else if (value == SYM_LANE_MARK)  return OCT_LANE_MARK;
        else if (value == SYM_FRAME_MARK) return OCT_FRAME_MARK;
        else                              return OCT_OTHER_CTRL;
    endfunction

endpackage

// File: rtl/lane_descrambler.sv
`timescale 1ns/1ps
module lane_descrambler #(
    parameter int unsigned W        = 16,
    parameter int unsigned TAP_NEAR = 14,
    parameter int unsigned TAP_FAR  = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned HIST_W = TAP_FAR;
    localparam int unsigned EXT_W  = HIST_W + W;

    // hist_q[0] is the most recently received bit
    logic [HIST_W-1:0] hist_q;
    logic [EXT_W-1:0]  ext;

    // Higher index = earlier in the serial stream
    assign ext = {hist_q, din};

    generate
        for (genvar k = 0; k < W; k++) begin : g_bit
            assign dout[k] = ext[k] ^ ext[k + TAP_NEAR] ^ ext[k + TAP_FAR];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (advance) begin
            hist_q <= ext[HIST_W-1:0];
        end
    end

    AST_HIST_FROM_RX: assert property (@(posedge clk) disable iff (rst)
        advance |=> (ext[EXT_W-1 -: HIST_W] == $past(ext[HIST_W-1:0]))); // R5

endmodule

// File: rtl/octet_substitute.sv
`timescale 1ns/1ps
module octet_substitute
    import lanerx_pkg::*;
(
    input  logic [OCT_W-1:0] raw,
    input  logic [OCT_W-1:0] descr,
    input  logic             is_ctrl,
    input  logic             scr_on,
    input  logic [OCT_W-1:0] prev,
    output logic [OCT_W-1:0] result
);
    octet_kind_e kind;

    assign kind = classify_octet(raw, is_ctrl);

    always_comb begin
        unique case (kind)
            OCT_LANE_MARK:  result = scr_on ? SYM_LANE_MARK  : prev;
            OCT_FRAME_MARK: result = scr_on ? SYM_FRAME_MARK : prev;
            OCT_OTHER_CTRL: result = scr_on ? descr : raw;
            OCT_DATA:       result = scr_on ? descr : raw;
            default:        result = raw;
        endcase
    end

endmodule

// File: rtl/lane_descramble_replace.sv
`timescale 1ns/1ps
module lane_descramble_replace
    import lanerx_pkg::*;
#(
    parameter int unsigned OCTETS   = 2,
    parameter int unsigned TAP_NEAR = 14,
    parameter int unsigned TAP_FAR  = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scr_en,
    input  logic                      in_valid,
    input  logic [OCTETS-1:0]         in_ctrl,
    input  logic [OCTETS*OCT_W-1:0]   in_data,
    output logic                      out_valid,
    output logic [OCTETS*OCT_W-1:0]   out_data
);
    localparam int unsigned WORD_W = OCTETS * OCT_W;

    logic [WORD_W-1:0]            descr_word;
    logic [WORD_W-1:0]            next_word;
    logic [OCTETS:0][OCT_W-1:0]   prev_chain;
    logic [OCT_W-1:0]             prev_q;

    lane_descrambler #(
        .W        (WORD_W),
        .TAP_NEAR (TAP_NEAR),
        .TAP_FAR  (TAP_FAR)
    ) descr_i (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid),
        .din     (in_data),
        .dout    (descr_word)
    );

    assign prev_chain[0] = prev_q;

    // Octet j = 0 is the earliest in the stream (most significant)
    generate
        for (genvar j = 0; j < OCTETS; j++) begin : g_oct
            localparam int unsigned HI = WORD_W - 1 - j * OCT_W;
            octet_substitute sub_i (
                .raw     (in_data[HI -: OCT_W]),
                .descr   (descr_word[HI -: OCT_W]),
                .is_ctrl (in_ctrl[OCTETS-1-j]),
                .scr_on  (scr_en),
                .prev    (prev_chain[j]),
                .result  (prev_chain[j+1])
            );
            assign next_word[HI -: OCT_W] = prev_chain[j+1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            prev_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_word;
                prev_q   <= prev_chain[OCTETS];
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R3
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !scr_en && in_ctrl == '0) |=> (out_data == $past(in_data))); // R6
    AST_PLAIN_REPLACE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !scr_en && in_ctrl[OCTETS-1] &&
         (in_data[WORD_W-1 -: OCT_W] == SYM_LANE_MARK ||
          in_data[WORD_W-1 -: OCT_W] == SYM_FRAME_MARK))
        |=> (out_data[WORD_W-1 -: OCT_W] == $past(out_data[OCT_W-1:0]))); // R7
    AST_SCR_LANE_MARK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scr_en && in_ctrl[OCTETS-1] &&
         in_data[WORD_W-1 -: OCT_W] == SYM_LANE_MARK)
        |=> (out_data[WORD_W-1 -: OCT_W] == SYM_LANE_MARK)); // R8

endmodule

// File: tb/lane_descramble_replace_tb_top.sv
`timescale 1ns/1ps
module lane_descramble_replace_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scr_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_ctrl = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    logic [14:0] m_hist = '0;   // m_hist[0] = most recent received bit
    logic [7:0]  m_prev = '0;
    logic [15:0] exp_data = '0;

    always #2.5 clk = ~clk;

    lane_descramble_replace dut_i (
        .clk       (clk),
        .rst       (rst),
        .scr_en    (scr_en),
        .in_valid  (in_valid),
        .in_ctrl   (in_ctrl),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Serial model: bit 15 first, bits 14 and 15 positions back
    task automatic model_word(input logic [15:0] d, input logic [1:0] k, input bit scr,
                              output logic [15:0] r, output bit repl);
        logic [15:0] ds;
        logic [7:0]  raw, dsc, o;
        repl = 0;
        for (int b = 15; b >= 0; b--) begin
            ds[b]  = d[b] ^ m_hist[13] ^ m_hist[14];
            m_hist = {m_hist[13:0], d[b]};
        end
        for (int j = 0; j < 2; j++) begin
            raw = (j == 0) ? d[15:8] : d[7:0];
            dsc = (j == 0) ? ds[15:8] : ds[7:0];
            if (k[1-j] && (raw == 8'h7C || raw == 8'hFC)) begin
                repl = 1;
                o = scr ? raw : m_prev;
            end else begin
                o = scr ? dsc : raw;
            end
            m_prev = o;
            if (j == 0) r[15:8] = o; else r[7:0] = o;
        end
    endtask

    task automatic step(input bit v, input logic [1:0] k, input logic [15:0] d,
                        input bit scr, input string tag);
        logic [15:0] r;
        bit repl;
        string t;
        in_valid = v; in_ctrl = k; in_data = d; scr_en = scr;
        t = tag;
        if (v) begin
            model_word(d, k, scr, r, repl);
            exp_data = r;
            if (t == "") t = scr ? (repl ? "R8" : "R4") : (repl ? "R7" : "R6");
        end else if (t == "") begin
            t = "R3";
        end
        @(negedge clk);
        check("R2 valid", {15'b0, out_valid}, {15'b0, v});
        check(t, out_data, exp_data);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_hist = '0; m_prev = '0; exp_data = '0;
        check("R1 valid", {15'b0, out_valid}, 16'h0);
        check("R1 data", out_data, 16'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=hang expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] first_out;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1 / R4: first scrambled words against zero history
        step(1, 2'b00, 16'h8001, 1, "R1 zero history");
        step(1, 2'b00, 16'hA5C3, 1, "R4");
        step(1, 2'b00, 16'h0000, 1, "R4");

        // R3: idle cycles with changing input do not disturb state
        step(0, 2'b11, 16'h7C7C, 0, "R3 hold");
        step(0, 2'b00, 16'h1234, 1, "R3 hold");
        step(1, 2'b00, 16'h5A5A, 1, "R3 state kept");

        // R6: plain pass, including flagged non-marker octets
        step(1, 2'b00, 16'h7CFC, 0, "R6");
        step(1, 2'b11, 16'hBC1C, 0, "R6 other ctrl");

        // R7: chained replacement in plain mode
        step(1, 2'b00, 16'h3344, 0, "R6");
        step(1, 2'b11, 16'h7CFC, 0, "R7 both replaced");
        step(1, 2'b01, 16'h99FC, 0, "R7 second uses first");

        // R8 / R10: scrambled markers, then switch back to plain
        step(1, 2'b11, 16'h7CFC, 1, "R8 markers");
        step(1, 2'b10, 16'hFC7C, 1, "R8 unflagged second");
        step(1, 2'b10, 16'h7C00, 0, "R10 prev across switch");

        // R9: mode switches each word
        for (int i = 0; i < 8; i++)
            step(1, 2'b00, 16'(16'h1357 * (i + 1)), (i % 2) == 0, "R9 switch");

        // R5: same words after a different prefix give the same outputs
        do_reset();
        step(1, 2'h0, 16'h1111, 1, "R5");
        step(1, 2'h0, 16'hCAFE, 1, "R5");
        step(1, 2'h0, 16'hBEEF, 1, "R5");
        first_out = out_data;
        step(1, 2'h0, 16'h0F0F, 1, "R5");
        step(1, 2'h0, 16'hCAFE, 1, "R5");
        step(1, 2'h0, 16'hBEEF, 1, "R5");
        check("R5 self sync", out_data, first_out);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            logic [1:0]  k;
            bit v, scr;
            v   = ($urandom % 4) != 0;
            scr = ($urandom % 3) != 0;
            k   = 2'($urandom);
            d   = 16'($urandom);
            if ($urandom % 3 == 0) d[15:8] = ($urandom % 2) ? 8'h7C : 8'hFC;
            if ($urandom % 3 == 0) d[7:0]  = ($urandom % 2) ? 8'h7C : 8'hFC;
            step(v, k, d, scr, "");
            if (i == 1500) do_reset();
        end

        in_valid = 1'b0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule